// File: doc/BRIEF.md
# Eight-Channel Match Timer Bank

This block holds eight timer channels, numbered 4 to 11, each with a 32-bit counter, a 32-bit match value and a match-control word. Every counter can step on one of five rate strobes: 32.768 kHz, 1 kHz, 1 Hz, 1 MHz and an external source. The strobes come from outside the block, and a counter advances by one only in a cycle where its selected strobe is high. A channel compares its match value with either its own counter or the counter that leads its group. When the compared counter steps onto the match value, the channel fires. A firing can clear that counter and, if the channel is enabled, sets the channel's status bit. A single interrupt line stays high while any status bit is set.

Software reaches the block through a simple register bus with one-cycle strobes. The counters sit at 0x40 + 4*(ch-4), the match values at 0x80 + 4*(ch-4) and the control words at 0xC0 + 4*(ch-4). The status word is at 0x14, the interrupt enables at 0x1C and the snapshot word at 0x20. Status and enable bit `ch` (4..11) belongs to channel `ch`. Status bits are cleared by writing a 1 to them. Channels 9 and 11 can be set so that a read of their own counter also copies the count of channel 8 or 10 into the snapshot word.

Top module: `timx_bank`

## Requirements
- R1: After reset, every counter, match value, control word, enable bit, status bit and the snapshot word read as zero, and `irq` is low.
- R2: Control bits [2:0] pick the counter's strobe: 1 = `tick_32k`, 2 = `tick_1k`, 3 = `tick_1hz`, 4 = `tick_1m`, 5 = `tick_ext`. Codes 0, 6 and 7 hold the counter. A running counter gains exactly one in each cycle where its chosen strobe is high and holds in every other cycle.
- R3: When control bit 7 is clear, channels 4–7 compare against counter 4, channels 8–9 against counter 8 and channels 10–11 against counter 10. When bit 7 is set, a channel compares against its own counter.
- R4: Counters 4, 8 and 10 always run at their selected rate. Any other counter runs only when its control bit 7 is set.
- R5: With control bit 3 set, a match loads zero into the compared counter instead of the match value.
- R6: A write to a match register arms that channel. With control bit 6 clear, the channel fires once and is then disarmed. With bit 6 set, it fires on every later match.
- R7: Control words of channels 4–7 keep bits [7:0]. Those of channels 8–11 keep bits [9:0]. All other bits read back as zero.
- R8: On channels 8–11, control bit 8 stops the counter whatever the rate code.
- R9: On channels 9 and 11 with control bit 9 set, reading the channel's own counter copies the current count of counter 8 (or 10) into the snapshot word at 0x20. With bit 9 clear, the read leaves the snapshot unchanged.
- R10: A firing sets status bit `ch` only if enable bit `ch` (register 0x1C) is set.
- R11: `irq` is high while any status bit 11..4 is set. Writing 1s to 0x14 clears those bits, and `irq` falls once no status bit remains set.
- R12: A bus write to a counter loads the written value, and the write takes priority over a strobe in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (drives snapshot capture) |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the addressed register |
| tick_32k | input | 1 | 32.768 kHz step strobe |
| tick_1k | input | 1 | 1 kHz step strobe |
| tick_1hz | input | 1 | 1 Hz step strobe |
| tick_1m | input | 1 | 1 MHz step strobe |
| tick_ext | input | 1 | External step strobe |
| irq | output | 1 | Combined channel interrupt |

## Verification
The counters are driven with trains of pulses on the selected strobe mixed with pulses on strobes that are not selected, and with rate codes that stop the counter. This separates correct strobe selection from counting on every strobe. Matching is exercised on channel 5 against the shared counter 4 in one-shot, re-armed and periodic-with-clear modes, and then with the enable turned off. Each mode leaves a distinct pair of values in the counter and the status word. The snapshot is read after reads of the channel 9 counter with bit 9 set and with bit 9 clear, so a snapshot that never updates and one that always updates both show up.

// File: rtl/timx_pkg.sv
package timx_pkg;

    localparam int NCH      = 8;
    localparam int CW       = 32;
    localparam int CTLW     = 10;
    localparam int NSRC     = 5;
    localparam int AW       = 8;
    localparam int IDXW     = $clog2(NCH);

    localparam logic [2:0]    GRP_CNT   = 3'b010;
    localparam logic [2:0]    GRP_MATCH = 3'b100;
    localparam logic [2:0]    GRP_CTRL  = 3'b110;
    localparam logic [AW-1:0] A_SNAP    = 8'h20;
    localparam logic [AW-1:0] A_STAT    = 8'h14;
    localparam logic [AW-1:0] A_IEN     = 8'h1C;

    typedef logic [CW-1:0] cnt_t;

    typedef struct packed {
        logic       snap_on;
        logic       sync_off;
        logic       own_cnt;
        logic       periodic;
        logic [1:0] spare;
        logic       clr_match;
        logic [2:0] src;
    } ctl_t;

    function automatic logic [IDXW-1:0] base_of(input int n);
        if (n < 4)      return IDXW'(0);
        else if (n < 6) return IDXW'(4);
        else            return IDXW'(6);
    endfunction

    function automatic logic is_base(input int n);
        return (n == 0) || (n == 4) || (n == 6);
    endfunction

    function automatic logic [CTLW-1:0] ctl_mask(input int n);
        return (n < 4) ? CTLW'(10'h0FF) : CTLW'(10'h3FF);
    endfunction

    function automatic logic tick_pick(input logic [2:0] src, input logic [NSRC-1:0] t);
        case (src)
            3'd1:    return t[0];
            3'd2:    return t[1];
            3'd3:    return t[2];
            3'd4:    return t[3];
            3'd5:    return t[4];
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/timx_counter.sv
module timx_counter
    import timx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic adv,
    input  logic ld,
    input  cnt_t ld_val,
    input  logic clr,
    output cnt_t cnt
);

    always_ff @(posedge clk) begin
        if (rst)      cnt <= '0;
        else if (ld)  cnt <= ld_val;
        else if (clr) cnt <= '0;
        else if (adv) cnt <= cnt + CW'(1);
    end

    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        (!ld && !clr && !adv) |=> $stable(cnt));
    a_r2_step: assert property (@(posedge clk) disable iff (rst)
        (!ld && !clr && adv) |=> cnt == $past(cnt) + CW'(1));
    a_r12_load: assert property (@(posedge clk) disable iff (rst)
        ld |=> cnt == $past(ld_val));

endmodule

// File: rtl/timx_match.sv
module timx_match
    import timx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic periodic,
    input  logic cmp_adv,
    input  cnt_t cmp_cnt,
    input  cnt_t match_val,
    output logic fire
);

    logic armed;

    assign fire = armed && cmp_adv && ((cmp_cnt + CW'(1)) == match_val);

    always_ff @(posedge clk) begin
        if (rst)                     armed <= 1'b0;
        else if (arm)                armed <= 1'b1;
        else if (fire && !periodic)  armed <= 1'b0;
    end

    a_r6_oneshot: assert property (@(posedge clk) disable iff (rst)
        (fire && !periodic && !arm) |=> !fire);

endmodule

// File: rtl/timx_status.sv
module timx_status
    import timx_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] fire,
    input  logic [NCH-1:0] ien,
    input  logic           clr_wr,
    input  logic [NCH-1:0] clr_bits,
    output logic [NCH-1:0] status,
    output logic           irq
);

    logic [NCH-1:0] clr_mask;

    assign clr_mask = clr_wr ? clr_bits : '0;

    always_ff @(posedge clk) begin
        if (rst) status <= '0;
        else     status <= (status & ~clr_mask) | (fire & ien);
    end

    assign irq = |status;

    a_r10_set: assert property (@(posedge clk) disable iff (rst)
        (|(fire & ien)) |=> irq);
    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        (!clr_wr && !(|(fire & ien))) |=> $stable(status));

endmodule

// File: rtl/timx_bank.sv
module timx_bank
    import timx_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [7:0]    bus_addr,
    input  logic [31:0]   bus_wdata,
    output logic [31:0]   bus_rdata,
    input  logic          tick_32k,
    input  logic          tick_1k,
    input  logic          tick_1hz,
    input  logic          tick_1m,
    input  logic          tick_ext,
    output logic          irq
);

    logic [NSRC-1:0] ticks;
    assign ticks = {tick_ext, tick_1m, tick_1hz, tick_1k, tick_32k};

    logic [2:0]      grp;
    logic [IDXW-1:0] idx;
    logic            aligned;
    assign grp     = bus_addr[7:5];
    assign idx     = bus_addr[4:2];
    assign aligned = (bus_addr[1:0] == 2'b00);

    ctl_t           ctrl  [NCH];
    cnt_t           mval  [NCH];
    cnt_t           cnt   [NCH];
    logic [NCH-1:0] ld_cnt, wr_match, adv, clr, fire;
    logic [IDXW-1:0] cmp_idx [NCH];
    logic [NCH-1:0] ien, status;
    cnt_t           snap;

    for (genvar k = 0; k < NCH; k++) begin : g_ch
        logic run, tick_ok;

        assign ld_cnt[k]   = bus_wr && aligned && grp == GRP_CNT   && idx == IDXW'(k);
        assign wr_match[k] = bus_wr && aligned && grp == GRP_MATCH && idx == IDXW'(k);

        always_ff @(posedge clk) begin
            if (rst) begin
                ctrl[k] <= '0;
                mval[k] <= '0;
            end else begin
                if (bus_wr && aligned && grp == GRP_CTRL && idx == IDXW'(k))
                    ctrl[k] <= ctl_t'(bus_wdata[CTLW-1:0] & ctl_mask(k));
                if (wr_match[k])
                    mval[k] <= bus_wdata;
            end
        end

        assign run     = ctrl[k].own_cnt || is_base(k);
        assign tick_ok = tick_pick(ctrl[k].src, ticks) && !ctrl[k].sync_off;
        assign adv[k]  = run && tick_ok && !ld_cnt[k];
        assign cmp_idx[k] = ctrl[k].own_cnt ? IDXW'(k) : base_of(k);

        timx_counter u_cnt (
            .clk    (clk),
            .rst    (rst),
            .adv    (adv[k]),
            .ld     (ld_cnt[k]),
            .ld_val (bus_wdata),
            .clr    (clr[k]),
            .cnt    (cnt[k])
        );

        timx_match u_match (
            .clk       (clk),
            .rst       (rst),
            .arm       (wr_match[k]),
            .periodic  (ctrl[k].periodic),
            .cmp_adv   (adv[cmp_idx[k]]),
            .cmp_cnt   (cnt[cmp_idx[k]]),
            .match_val (mval[k]),
            .fire      (fire[k])
        );
    end

    always_comb begin
        clr = '0;
        for (int n = 0; n < NCH; n++)
            if (fire[n] && ctrl[n].clr_match)
                clr[cmp_idx[n]] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            ien <= '0;
        else if (bus_wr && bus_addr == A_IEN)
            ien <= bus_wdata[NCH+3:4];
    end

    logic snap_take;
    assign snap_take = bus_rd && aligned && grp == GRP_CNT
                     && (idx == IDXW'(5) || idx == IDXW'(7)) && ctrl[idx].snap_on;

    always_ff @(posedge clk) begin
        if (rst)            snap <= '0;
        else if (snap_take) snap <= cnt[idx - IDXW'(1)];
    end

    a_r9_snap: assert property (@(posedge clk) disable iff (rst)
        !snap_take |=> $stable(snap));

    timx_status u_status (
        .clk      (clk),
        .rst      (rst),
        .fire     (fire),
        .ien      (ien),
        .clr_wr   (bus_wr && bus_addr == A_STAT),
        .clr_bits (bus_wdata[NCH+3:4]),
        .status   (status),
        .irq      (irq)
    );

    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            case (grp)
                GRP_CNT:   bus_rdata = cnt[idx];
                GRP_MATCH: bus_rdata = mval[idx];
                GRP_CTRL:  bus_rdata = 32'(ctrl[idx]);
                default: begin
                    if (bus_addr == A_SNAP)      bus_rdata = snap;
                    else if (bus_addr == A_STAT) bus_rdata = {20'b0, status, 4'b0};
                    else if (bus_addr == A_IEN)  bus_rdata = {20'b0, ien, 4'b0};
                end
            endcase
        end
    end

endmodule

// File: tb/test_timx_bank.sv
`timescale 1ns/1ps
module test_timx_bank;

    logic        clk = 0;
    logic        rst = 1;
    logic        bus_wr = 0, bus_rd = 0;
    logic [7:0]  bus_addr = 0;
    logic [31:0] bus_wdata = 0;
    logic [31:0] bus_rdata;
    logic [4:0]  ticks = 0;
    logic        irq;

    int tests = 0, fails = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    timx_bank i_timx_bank (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tick_32k(ticks[0]), .tick_1k(ticks[1]), .tick_1hz(ticks[2]),
        .tick_1m(ticks[3]), .tick_ext(ticks[4]), .irq(irq)
    );

    // monitor: pops one expectation per read cycle
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (bus_rd) begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                tests++;
                if (bus_rdata !== e) begin
                    fails++;
                    $display("FAIL %s addr=%h actual=%h expected=%h", t, bus_addr, bus_rdata, e);
                end
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
        @(negedge clk);
        bus_rd = 1; bus_addr = a;
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk);
        bus_rd = 0;
    endtask

    task automatic pulse(input int sel, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ticks[sel] = 1'b1;
            @(negedge clk); ticks = '0;
        end
    endtask

    task automatic chk_irq(input logic e, input string t);
        @(negedge clk); #1;
        tests++;
        if (irq !== e) begin
            fails++;
            $display("FAIL %s irq actual=%b expected=%b", t, irq, e);
        end
    endtask

    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        // R1 reset state
        rd(8'h40, 0, "R1"); rd(8'hC0, 0, "R1"); rd(8'h14, 0, "R1");
        rd(8'h20, 0, "R1"); rd(8'h9C, 0, "R1");
        chk_irq(0, "R1");
        // R2 strobe selection
        wr(8'hC0, 1); pulse(0, 5); pulse(1, 3);
        rd(8'h40, 5, "R2");
        wr(8'hC0, 2); pulse(1, 3); pulse(0, 2);
        rd(8'h40, 8, "R2");
        wr(8'hC0, 6); for (int s = 0; s < 5; s++) pulse(s, 1);
        rd(8'h40, 8, "R2");
        wr(8'hC0, 5); pulse(4, 2); pulse(2, 1);
        rd(8'h40, 10, "R2");
        // R12 counter load
        wr(8'h40, 100); rd(8'h40, 100, "R12");
        wr(8'hC0, 0);
        // R4 non-base counter needs own bit
        wr(8'hC4, 1); pulse(0, 3); rd(8'h44, 0, "R4");
        wr(8'hC4, 32'h81); pulse(0, 3); rd(8'h44, 3, "R4");
        // R3 shared compare, R10 status, R11 irq
        wr(8'hC0, 1); wr(8'h40, 0); wr(8'h1C, 32'hFF0);
        wr(8'hC4, 0); wr(8'h84, 3);
        pulse(0, 3);
        rd(8'h40, 3, "R3"); rd(8'h14, 32'h20, "R10");
        chk_irq(1, "R11");
        wr(8'h14, 32'h10); chk_irq(1, "R11"); rd(8'h14, 32'h20, "R11");
        wr(8'h14, 32'h20); chk_irq(0, "R11"); rd(8'h14, 0, "R11");
        // R6 one-shot, then re-arm
        wr(8'h40, 0); pulse(0, 3); rd(8'h14, 0, "R6");
        wr(8'h84, 3); wr(8'h40, 0); pulse(0, 3); rd(8'h14, 32'h20, "R6");
        wr(8'h14, 32'hFF0);
        // R5 clear on match, R6 periodic
        wr(8'hC4, 32'h48); wr(8'h40, 0); wr(8'h84, 3);
        pulse(0, 3);
        rd(8'h14, 32'h20, "R5"); rd(8'h40, 0, "R5");
        wr(8'h14, 32'hFF0); pulse(0, 3);
        rd(8'h14, 32'h20, "R6"); rd(8'h40, 0, "R6");
        wr(8'h14, 32'hFF0);
        // R10 disabled channel
        wr(8'h1C, 0); wr(8'h40, 0); pulse(0, 3);
        rd(8'h40, 0, "R10"); rd(8'h14, 0, "R10"); chk_irq(0, "R10");
        // R7 control widths
        wr(8'hC8, 32'hFFFF); rd(8'hC8, 32'hFF, "R7");
        wr(8'hD4, 32'hFFFF); rd(8'hD4, 32'h3FF, "R7");
        // R8 sync-off stop
        wr(8'hD0, 32'h101); pulse(0, 4); rd(8'h50, 0, "R8");
        wr(8'hD0, 32'h001); pulse(0, 4); rd(8'h50, 4, "R8");
        // R9 snapshot
        wr(8'hD4, 32'h200);
        rd(8'h54, 0, "R9"); rd(8'h20, 4, "R9");
        wr(8'hD4, 0); pulse(0, 2);
        rd(8'h50, 6, "R9"); rd(8'h54, 0, "R9"); rd(8'h20, 4, "R9");
        repeat (3) @(negedge clk);
        tests++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL scoreboard actual=%0d expected=0 pending", exp_q.size());
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule